// File: doc/BRIEF.md
# Refresh-Triggered Aggressor Sampler and Victim Refresher

This block is a behavioural model of an in-memory defence against row disturbance. It watches the row address carried by every activate command and, under a selectable sampling policy, records suspected aggressor rows in a small table with a fixed number of entries and a saturating hit count per entry. Because the table is small, a pattern that hammers many distinct rows can push entries out of it.

Mitigation is driven only by the regular refresh command. When a refresh arrives and the table holds at least one row, the block picks the most-sampled row, pulses a victim-refresh strobe with the address of one physical neighbour of that row, and frees the entry. At most one neighbour is refreshed per refresh, and the strobe follows the refresh by one clock, so it fits inside the refresh cycle time. Several aggressors may be sampled between two refreshes. The sampling policy is chosen on a pin: every Nth activation, the first N activations after a refresh, or a pseudo-random coin flip whose probability is set by a threshold.

Top module: `trr_guard`

## Requirements
- R1: After reset, `occupancy` is 0 and `vicValid` is low.
- R2: With `policy` = 0, every Nth accepted activation is sampled, where N is `sampleN` (0 counts as 1). The activation counter starts at 0 after reset, is not cleared by refresh, and restarts after each sampled activation.
- R3: With `policy` = 1, the first N accepted activations after reset or after the most recent refresh are sampled, and later ones are not.
- R4: With `policy` = 2, an activation is sampled when an 8-bit LFSR value is below `coinThresh`. The LFSR resets to 8'hA5 and advances on every accepted activation, whatever the policy, to {s[6:0], s[7]^s[5]^s[4]^s[3]}. The value before the advance is the one compared. A threshold of 0 samples nothing. `policy` = 3 samples nothing.
- R5: A sampled row that matches a valid entry increments that entry's count, which saturates at 15 and does not wrap. Otherwise the row goes into the lowest-index free entry with a count of 1.
- R6: When the table is full, a sampled row that matches no entry replaces the entry with the lowest count, with ties going to the lowest index, and the new entry gets a count of 1.
- R7: A refresh with a non-empty table selects the valid entry with the highest count, with ties going to the lowest index. `vicValid` pulses for exactly the cycle after the refresh, the entry is freed, and `occupancy` drops by one.
- R8: A refresh with an empty table produces no strobe. No strobe ever appears except in the cycle after a refresh.
- R9: The victim is the aggressor + 1, modulo 2^ROW_W. If the aggressor is the same row as the one served at the previous victim refresh, the side is reversed: the victim is the aggressor − 1 if the previous victim was + 1, and the reverse.
- R10: An activate in the same cycle as a refresh is ignored. It is not sampled, it does not advance the counters or the LFSR, and it does not change `occupancy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| actValid | input | 1 | Activate command strobe |
| refValid | input | 1 | Regular refresh command strobe |
| rowAddr | input | ROW_W | Row address of the activate |
| policy | input | 2 | Sampling policy: 0 every Nth, 1 first N, 2 random, 3 off |
| sampleN | input | SEL_W | N for policies 0 and 1 |
| coinThresh | input | 8 | Random-sampling threshold |
| vicValid | output | 1 | Victim-refresh strobe |
| vicRow | output | ROW_W | Victim row address, valid with vicValid |
| occupancy | output | OCC_W | Number of valid table entries |

## Verification
The hardest states to reach from the ports combine a full table, a tie in counts on both the eviction side and the selection side, and a count driven past its saturation point. Directed sequences reach them. They fill the table with rows hit a known number of times, push one more distinct row in, and then drain the table with refreshes so that each choice shows up as a victim address. The every-activation policy lets one row collect seventeen hits, which would wrap a non-saturating counter. Repeatedly serving the top row checks the side reversal and the address wrap. A long random run over a few rows, with all policies and overlapping activate and refresh commands, is compared every cycle against a bench model.

// File: rtl/trr_pkg.sv
package trr_pkg;
  typedef enum logic [1:0] {
    POL_EVERY_NTH = 2'd0,
    POL_FIRST_N   = 2'd1,
    POL_COIN      = 2'd2,
    POL_OFF       = 2'd3
  } samplePolicy_e;

  // control -> datapath strobes
  typedef struct packed {
    logic record;   // sample the current activate row
    logic serve;    // a refresh is being handled
  } ctrlStrobes_t;
endpackage

// File: rtl/trr_ctrl.sv
module trr_ctrl
  import trr_pkg::*;
#(
  parameter int         SEL_W     = 4,
  parameter logic [7:0] LFSR_SEED = 8'hA5
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             actValid,
  input  logic             refValid,
  input  logic [1:0]       policy,
  input  logic [SEL_W-1:0] sampleN,
  input  logic [7:0]       coinThresh,
  output ctrlStrobes_t     strobes
);
  localparam logic [SEL_W-1:0] SINCE_MAX = '1;

  logic [SEL_W-1:0] freqCnt;
  logic [SEL_W-1:0] sinceRef;
  logic [7:0]       lfsr;
  logic [SEL_W-1:0] nEff;
  logic [SEL_W:0]   freqNext;
  logic             actTake, freqHit, timeHit, coinHit, hit;

  // R10: a refresh in the same cycle masks the activate
  assign actTake  = actValid & ~refValid;
  assign nEff     = (sampleN == '0) ? SEL_W'(1) : sampleN;
  assign freqNext = {1'b0, freqCnt} + 1'b1;
  assign freqHit  = freqNext >= {1'b0, nEff};              // R2
  assign timeHit  = sinceRef < nEff;                       // R3
  assign coinHit  = lfsr < coinThresh;                     // R4

  always_comb begin
    unique case (samplePolicy_e'(policy))
      POL_EVERY_NTH: hit = freqHit;
      POL_FIRST_N:   hit = timeHit;
      POL_COIN:      hit = coinHit;
      default:       hit = 1'b0;
    endcase
  end

  assign strobes.record = actTake & hit;
  assign strobes.serve  = refValid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freqCnt  <= '0;
      sinceRef <= '0;
      lfsr     <= LFSR_SEED;
    end else begin
      if (refValid) begin
        sinceRef <= '0;
      end else if (actTake) begin
        if (sinceRef != SINCE_MAX) sinceRef <= sinceRef + 1'b1;
      end
      if (actTake) begin
        freqCnt <= freqHit ? '0 : freqNext[SEL_W-1:0];
        lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      end
    end
  end
endmodule

// File: rtl/trr_table.sv
module trr_table
  import trr_pkg::*;
#(
  parameter int ROW_W   = 8,
  parameter int ENTRIES = 4,
  parameter int CNT_W   = 4,
  parameter int OCC_W   = 3
)(
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobes_t     strobes,
  input  logic [ROW_W-1:0] rowAddr,
  output logic             vicValid,
  output logic [ROW_W-1:0] vicRow,
  output logic [OCC_W-1:0] occupancy
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [ENTRIES-1:0] valid;
  logic [ROW_W-1:0]   rows [ENTRIES];
  logic [CNT_W-1:0]   cnts [ENTRIES];
  logic [ENTRIES-1:0] matchVec;

  logic             matchAny, freeAny, anyValid;
  logic [IDX_W-1:0] matchIdx, freeIdx, minIdx, maxIdx;
  logic [CNT_W-1:0] minCnt, maxCnt;

  logic             lastValid, lastSide, newSide;
  logic [ROW_W-1:0] lastRow, aggrRow;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
      assign matchVec[g] = valid[g] && (rows[g] == rowAddr);
    end
  endgenerate

  // lowest-index match and lowest-index free slot (R5)
  always_comb begin
    matchAny = 1'b0; matchIdx = '0;
    freeAny  = 1'b0; freeIdx  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i] && !matchAny) begin
        matchAny = 1'b1; matchIdx = IDX_W'(i);
      end
      if (!valid[i] && !freeAny) begin
        freeAny = 1'b1; freeIdx = IDX_W'(i);
      end
    end
  end

  // eviction candidate: lowest count, first index on ties (R6)
  always_comb begin
    minIdx = '0; minCnt = CNT_MAX;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (cnts[i] <= minCnt) begin
        minCnt = cnts[i]; minIdx = IDX_W'(i);
      end
    end
  end

  // service candidate: highest count, first index on ties (R7)
  always_comb begin
    anyValid = 1'b0; maxIdx = '0; maxCnt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (valid[i] && (!anyValid || cnts[i] > maxCnt)) begin
        anyValid = 1'b1; maxCnt = cnts[i]; maxIdx = IDX_W'(i);
      end
    end
  end

  // R9: side alternation for a repeatedly served aggressor
  assign aggrRow = rows[maxIdx];
  assign newSide = (lastValid && lastRow == aggrRow) ? ~lastSide : 1'b0;

  always_comb begin
    occupancy = '0;
    for (int i = 0; i < ENTRIES; i++) occupancy = occupancy + OCC_W'(valid[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid     <= '0;
      vicValid  <= 1'b0;
      vicRow    <= '0;
      lastValid <= 1'b0;
      lastSide  <= 1'b0;
      lastRow   <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        rows[i] <= '0;
        cnts[i] <= '0;
      end
    end else begin
      vicValid <= strobes.serve && anyValid;   // R8
      if (strobes.serve) begin
        if (anyValid) begin
          valid[maxIdx] <= 1'b0;
          vicRow        <= newSide ? aggrRow - 1'b1 : aggrRow + 1'b1;
          lastRow       <= aggrRow;
          lastValid     <= 1'b1;
          lastSide      <= newSide;
        end
      end else if (strobes.record) begin
        if (matchAny) begin
          if (cnts[matchIdx] != CNT_MAX) cnts[matchIdx] <= cnts[matchIdx] + 1'b1;
        end else if (freeAny) begin
          valid[freeIdx] <= 1'b1;
          rows[freeIdx]  <= rowAddr;
          cnts[freeIdx]  <= CNT_W'(1);
        end else begin
          rows[minIdx] <= rowAddr;
          cnts[minIdx] <= CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/trr_guard.sv
module trr_guard
  import trr_pkg::*;
#(
  parameter int         ROW_W     = 8,
  parameter int         ENTRIES   = 4,
  parameter int         CNT_W     = 4,
  parameter int         SEL_W     = 4,
  parameter logic [7:0] LFSR_SEED = 8'hA5,
  localparam int        OCC_W     = $clog2(ENTRIES + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             actValid,
  input  logic             refValid,
  input  logic [ROW_W-1:0] rowAddr,
  input  logic [1:0]       policy,
  input  logic [SEL_W-1:0] sampleN,
  input  logic [7:0]       coinThresh,
  output logic             vicValid,
  output logic [ROW_W-1:0] vicRow,
  output logic [OCC_W-1:0] occupancy
);
  ctrlStrobes_t strobes;

  trr_ctrl #(.SEL_W(SEL_W), .LFSR_SEED(LFSR_SEED)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .actValid(actValid), .refValid(refValid),
    .policy(policy), .sampleN(sampleN), .coinThresh(coinThresh),
    .strobes(strobes)
  );

  trr_table #(.ROW_W(ROW_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W), .OCC_W(OCC_W)) u_table (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .rowAddr(rowAddr),
    .vicValid(vicValid), .vicRow(vicRow), .occupancy(occupancy)
  );
endmodule

// File: rtl/trr_guard_chk.sv
module trr_guard_chk #(
  parameter int ROW_W   = 8,
  parameter int ENTRIES = 4,
  parameter int OCC_W   = 3
)(
  input logic             clk,
  input logic             rst_n,
  input logic             actValid,
  input logic             refValid,
  input logic             vicValid,
  input logic [OCC_W-1:0] occupancy
);
  assert_occ_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= OCC_W'(ENTRIES));

  assert_strobe_after_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vicValid |-> $past(refValid));

  assert_empty_ref_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (refValid && occupancy == '0) |=> !vicValid);

  assert_ref_serves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (refValid && occupancy != '0) |=> (vicValid && occupancy == OCC_W'($past(occupancy) - 1'b1)));

  assert_act_grows_by_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !refValid |=> (occupancy >= $past(occupancy) && occupancy <= OCC_W'($past(occupancy) + 1'b1)));

  assert_ref_no_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (refValid && actValid && occupancy == '0) |=> occupancy == '0);
endmodule

bind trr_guard trr_guard_chk #(.ROW_W(ROW_W), .ENTRIES(ENTRIES), .OCC_W(OCC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .actValid(actValid), .refValid(refValid),
  .vicValid(vicValid), .occupancy(occupancy)
);

// File: tb/trr_guard_tb.sv
module trr_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NENT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       actValid = 1'b0, refValid = 1'b0;
  logic [7:0] rowAddr = '0;
  logic [1:0] policy = 2'd0;
  logic [3:0] sampleN = 4'd1;
  logic [7:0] coinThresh = 8'd0;
  logic       vicValid;
  logic [7:0] vicRow;
  logic [2:0] occupancy;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trr_guard u_dut (
    .clk(clk), .rst_n(rst_n), .actValid(actValid), .refValid(refValid),
    .rowAddr(rowAddr), .policy(policy), .sampleN(sampleN), .coinThresh(coinThresh),
    .vicValid(vicValid), .vicRow(vicRow), .occupancy(occupancy)
  );

  // reference model state
  bit       mValid [NENT];
  bit [7:0] mRow   [NENT];
  int       mCnt   [NENT];
  int       mFreq, mSince;
  bit [7:0] mLfsr;
  bit       mLastValid, mLastSide;
  bit [7:0] mLastRow;
  bit       expVic;
  bit [7:0] expRow;

  task automatic modelReset();
    for (int i = 0; i < NENT; i++) begin mValid[i] = 0; mRow[i] = 0; mCnt[i] = 0; end
    mFreq = 0; mSince = 0; mLfsr = 8'hA5;
    mLastValid = 0; mLastSide = 0; mLastRow = 0; expVic = 0; expRow = 0;
  endtask

  function automatic int modelOcc();
    int n = 0;
    for (int i = 0; i < NENT; i++) n += int'(mValid[i]);
    return n;
  endfunction

  task automatic modelInsert(input bit [7:0] row);
    int slot = -1;
    for (int i = 0; i < NENT; i++) if (slot < 0 && mValid[i] && mRow[i] == row) slot = i;
    if (slot >= 0) begin
      if (mCnt[slot] < 15) mCnt[slot]++;
      return;
    end
    for (int i = 0; i < NENT; i++) if (slot < 0 && !mValid[i]) slot = i;
    if (slot < 0) begin
      slot = 0;
      for (int i = 1; i < NENT; i++) if (mCnt[i] < mCnt[slot]) slot = i;
    end
    mValid[slot] = 1; mRow[slot] = row; mCnt[slot] = 1;
  endtask

  task automatic modelStep(input bit a, input bit r, input bit [7:0] row);
    expVic = 0;
    if (r) begin
      int best = -1;
      mSince = 0;
      for (int i = 0; i < NENT; i++)
        if (mValid[i] && (best < 0 || mCnt[i] > mCnt[best])) best = i;
      if (best >= 0) begin
        bit side = (mLastValid && mLastRow == mRow[best]) ? !mLastSide : 1'b0;
        expRow = side ? mRow[best] - 8'd1 : mRow[best] + 8'd1;
        expVic = 1; mValid[best] = 0;
        mLastRow = mRow[best]; mLastValid = 1; mLastSide = side;
      end
    end else if (a) begin
      int n = (sampleN == 0) ? 1 : int'(sampleN);
      bit hit;
      case (policy)
        2'd0: hit = (mFreq + 1 >= n);
        2'd1: hit = (mSince < n);
        2'd2: hit = (mLfsr < coinThresh);
        default: hit = 0;
      endcase
      mFreq = (mFreq + 1 >= n) ? 0 : mFreq + 1;
      if (mSince < 15) mSince++;
      mLfsr = {mLfsr[6:0], mLfsr[7] ^ mLfsr[5] ^ mLfsr[4] ^ mLfsr[3]};
      if (hit) modelInsert(row);
    end
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at the falling edge, compare at the next falling edge
  task automatic step(input bit a, input bit r, input bit [7:0] row, input string tag);
    actValid = a; refValid = r; rowAddr = row;
    @(posedge clk);
    modelStep(a, r, row);
    @(negedge clk);
    actValid = 0; refValid = 0;
    check(vicValid === expVic, {tag, " vicValid"}, int'(vicValid), int'(expVic));
    if (expVic) check(vicRow === expRow, {tag, " vicRow"}, int'(vicRow), int'(expRow));
    check(occupancy === 3'(modelOcc()), {tag, " occupancy"}, int'(occupancy), modelOcc());
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < NENT + 1; i++) step(0, 1, 8'd0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog R1..all actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    modelReset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(occupancy === 3'd0, "R1 reset occupancy", int'(occupancy), 0);
    check(vicValid === 1'b0, "R1 reset vicValid", int'(vicValid), 0);

    // R2: every third activation
    policy = 2'd0; sampleN = 4'd3;
    for (int i = 1; i <= 6; i++) step(1, 0, 8'(i), "R2 every-nth");
    check(occupancy === 3'd2, "R2 two samples", int'(occupancy), 2);
    step(0, 1, 0, "R7 serve first");
    check(vicRow === 8'd4, "R7 tie to lowest index", int'(vicRow), 4);
    step(0, 1, 0, "R7 serve second");
    step(0, 1, 0, "R8 empty refresh");
    check(vicValid === 1'b0, "R8 no strobe when empty", int'(vicValid), 0);

    // R3: first two after refresh
    policy = 2'd1; sampleN = 4'd2;
    step(1, 0, 8'd20, "R3"); step(1, 0, 8'd21, "R3"); step(1, 0, 8'd22, "R3");
    check(occupancy === 3'd2, "R3 only first N", int'(occupancy), 2);
    step(0, 1, 0, "R3 refresh restarts window");
    step(1, 0, 8'd30, "R3"); step(1, 0, 8'd31, "R3"); step(1, 0, 8'd32, "R3");
    drain("R3 drain");

    // R6: overflow replaces lowest count
    sampleN = 4'd15;
    for (int i = 0; i < 3; i++) step(1, 0, 8'd40, "R5 fill");
    step(1, 0, 8'd41, "R5 fill");
    for (int i = 0; i < 2; i++) begin step(1, 0, 8'd42, "R5 fill"); step(1, 0, 8'd43, "R5 fill"); end
    step(1, 0, 8'd44, "R6 overflow");
    check(occupancy === 3'd4, "R6 full table", int'(occupancy), 4);
    step(0, 1, 0, "R6 serve"); check(vicRow === 8'd41, "R6 highest count", int'(vicRow), 41);
    step(0, 1, 0, "R6 serve"); check(vicRow === 8'd43, "R6 tie lowest index", int'(vicRow), 43);
    step(0, 1, 0, "R6 serve"); check(vicRow === 8'd44, "R6 count order", int'(vicRow), 44);
    step(0, 1, 0, "R6 serve"); check(vicRow === 8'd45, "R6 evicted row gone", int'(vicRow), 45);

    // R9: alternation and wrap
    step(1, 0, 8'd255, "R9"); step(0, 1, 0, "R9");
    check(vicRow === 8'd0, "R9 wrap upward", int'(vicRow), 0);
    step(1, 0, 8'd255, "R9"); step(0, 1, 0, "R9");
    check(vicRow === 8'd254, "R9 alternate downward", int'(vicRow), 254);
    step(1, 0, 8'd255, "R9"); step(0, 1, 0, "R9");
    check(vicRow === 8'd0, "R9 alternate back", int'(vicRow), 0);

    // R10: simultaneous activate and refresh
    step(1, 1, 8'd60, "R10 collide empty");
    check(occupancy === 3'd0, "R10 act ignored", int'(occupancy), 0);
    step(1, 0, 8'd50, "R10");
    step(1, 1, 8'd60, "R10 collide");
    check(vicRow === 8'd51, "R10 serve during collision", int'(vicRow), 51);
    check(occupancy === 3'd0, "R10 colliding row not kept", int'(occupancy), 0);

    // R5: saturating count
    policy = 2'd0; sampleN = 4'd1;
    step(1, 0, 8'd80, "R5"); step(1, 0, 8'd80, "R5");
    for (int i = 0; i < 17; i++) step(1, 0, 8'd81, "R5 saturate");
    step(0, 1, 0, "R5");
    check(vicRow === 8'd82, "R5 count saturates", int'(vicRow), 82);
    drain("R5 drain");

    // R4: coin flip
    policy = 2'd2; coinThresh = 8'd0;
    for (int i = 0; i < 20; i++) step(1, 0, 8'(i), "R4 threshold zero");
    check(occupancy === 3'd0, "R4 zero threshold samples none", int'(occupancy), 0);
    coinThresh = 8'd128;
    for (int i = 0; i < 30; i++) step(1, 0, 8'(i % 5), "R4 coin");
    policy = 2'd3;
    drain("R4 drain");
    for (int i = 0; i < 10; i++) step(1, 0, 8'd3, "R4 off");
    check(occupancy === 3'd0, "R4 policy off", int'(occupancy), 0);

    // mixed random traffic
    for (int k = 0; k < 4000; k++) begin
      int sel = $urandom_range(0, 99);
      int pk = $urandom_range(0, 7);
      bit [7:0] row = (pk == 7) ? 8'd255 : 8'(pk);
      if (k % 250 == 0) begin
        policy = 2'($urandom_range(0, 3));
        sampleN = 4'($urandom_range(0, 15));
        coinThresh = 8'($urandom_range(0, 255));
      end
      if (sel < 60) step(1, 0, row, "R2 R3 R4 R5 R6 random act");
      else if (sel < 70) step(0, 1, row, "R7 R8 R9 random ref");
      else if (sel < 75) step(1, 1, row, "R10 random collide");
      else step(0, 0, row, "R8 random idle");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule